// File: doc/BRIEF.md
# Floating-Point Rounding and Exception Status Register

This block holds the state that a floating-point unit shares with software: a three-bit rounding-mode field and five sticky exception flags. Software reaches that state through three address-selected views of one eight-bit word. The first view holds the flags alone. The second holds the rounding mode alone. The third holds the whole word, with the mode above the flags. Each access reads, overwrites, sets bits in or clears bits in the selected view, and returns the value the view held before the access, in the same cycle.

The floating-point datapath raises exception flags through a separate accumulate input. Those flags are ORed into the stored flags and stay set until software clears them. When a software access modifies the flag field in the same cycle, the software value wins. The current mode and flags are driven out continuously to the datapath.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the rounding mode and the flags are both zero, and `rd_data` is zero while no access is presented.
- R2: The combined view (address `ADDR_ALL`) holds eight bits: the flags in bits 4:0 and the mode in bits 7:5. Writing 0x1234 and then reading returns 0x34. Bits of `rd_data` above bit 7 are zero for every view.
- R3: The flags view (address `ADDR_FLAGS`) reads bits 4:0 of the combined word, so a combined value of 0x34 reads as 0x14. Writing it changes only the flags.
- R4: The rounding-mode view (address `ADDR_RM`) maps to bits 7:5 of the combined word. Writing 2 when the mode is 1 returns 1 and turns a combined 0x34 into 0x54. The mode changes only through the mode view or the combined view.
- R5: `req_op` is encoded as 0 read, 1 write, 2 set bits (old OR data) and 3 clear bits (old AND NOT data). A clear of 4 on the flags view holding 0x14 returns 0x14 and leaves the combined word at 0x50.
- R6: Every access to a mapped address returns the view's value from before the access, in the same cycle, with `req_hit` high. With `req` low, `rd_data` is zero and `req_hit` is low.
- R7: When `acc_valid` is high and no access modifies the flag field, `acc_flags` is ORed into the stored flags at the next edge. Bit 4 is the invalid-operation flag and bit 0 is the inexact flag. Flags never clear without a software access.
- R8: In a cycle where a write, set or clear through the flags view or the combined view coincides with `acc_valid`, the flags take the software result and the accumulated bits are dropped. A mode-view access or a read-only access does not block accumulation.
- R9: An access to an address outside the three views returns zero with `req_hit` low and changes no state.
- R10: `rm_out` and `flags_out` always show the stored mode and flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Software access presented this cycle |
| req_addr | input | ADDR_W | Register address of the access |
| req_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| req_wdata | input | XLEN | Write data or bit mask |
| rd_data | output | XLEN | Value of the selected view before the access |
| req_hit | output | 1 | Address matched one of the three views |
| acc_valid | input | 1 | Datapath raises exception flags this cycle |
| acc_flags | input | FLAG_W | Exception flags to OR into the stored flags |
| rm_out | output | RM_W | Current rounding mode |
| flags_out | output | FLAG_W | Current accumulated flags |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 3-bit mode field, a 5-bit flag field and views at addresses 1, 2 and 3. This lets it write wide values such as 0x1234 and 0xFFFFFFE0 and confirm that only the field bits survive. A nearby unmapped address and an address that matches only in its low bits test decoding. Random traffic mixes all four operations with accumulate pulses in the same cycles, so the priority of software writes over accumulation is exercised on every view.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic flags;
    logic mode;
    logic whole;
  } view_sel_t;

  function automatic logic op_modifies(input csr_op_e op);
    return op != OP_READ;
  endfunction

endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import fpcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_FLAGS = 1,
  parameter logic [ADDR_W-1:0] ADDR_RM    = 2,
  parameter logic [ADDR_W-1:0] ADDR_ALL   = 3
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output view_sel_t         sel,
  output logic              hit
);

  always_comb begin
    sel       = '0;
    sel.flags = req && (addr == ADDR_FLAGS);
    sel.mode  = req && (addr == ADDR_RM);
    sel.whole = req && (addr == ADDR_ALL);
    hit       = sel.flags || sel.mode || sel.whole;
  end

endmodule

// File: rtl/fpcsr_field_reg.sv
module fpcsr_field_reg
  import fpcsr_pkg::*;
#(
  parameter int W     = 5,
  parameter bit ACCUM = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  csr_op_e      op,
  input  logic [W-1:0] mask,
  input  logic         acc_en,
  input  logic [W-1:0] acc_val,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] merge(input csr_op_e o, input logic [W-1:0] old,
                                         input logic [W-1:0] m);
    case (o)
      OP_WRITE: return m;
      OP_SET:   return old | m;
      OP_CLEAR: return old & ~m;
      default:  return old;
    endcase
  endfunction

  logic         sw_wr;
  logic [W-1:0] sw_val;
  logic [W-1:0] hw_val;

  assign sw_wr  = sel && op_modifies(op);
  assign sw_val = merge(op, q, mask);

  generate
    if (ACCUM) begin : g_accum
      assign hw_val = acc_en ? (q | acc_val) : q;
    end else begin : g_plain
      assign hw_val = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (sw_wr) q <= sw_val;
    else            q <= hw_val;
  end

endmodule

// File: rtl/fpcsr_read_mux.sv
module fpcsr_read_mux
  import fpcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RM_W   = 3,
  parameter int FLAG_W = 5
) (
  input  view_sel_t         sel,
  input  logic [RM_W-1:0]   rm_q,
  input  logic [FLAG_W-1:0] fl_q,
  output logic [XLEN-1:0]   rd_data
);

  localparam int WORD_W = RM_W + FLAG_W;

  logic [WORD_W-1:0] word;
  assign word = {rm_q, fl_q};

  always_comb begin
    rd_data = '0;
    if (sel.flags)      rd_data = XLEN'(fl_q);
    else if (sel.mode)  rd_data = XLEN'(rm_q);
    else if (sel.whole) rd_data = XLEN'(word);
  end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12,
  parameter int RM_W   = 3,
  parameter int FLAG_W = 5,
  parameter logic [ADDR_W-1:0] ADDR_FLAGS = 1,
  parameter logic [ADDR_W-1:0] ADDR_RM    = 2,
  parameter logic [ADDR_W-1:0] ADDR_ALL   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [XLEN-1:0]   req_wdata,
  output logic [XLEN-1:0]   rd_data,
  output logic              req_hit,
  input  logic              acc_valid,
  input  logic [FLAG_W-1:0] acc_flags,
  output logic [RM_W-1:0]   rm_out,
  output logic [FLAG_W-1:0] flags_out
);

  localparam int WORD_W = RM_W + FLAG_W;

  view_sel_t         sel;
  csr_op_e           op;
  logic              fl_sel, rm_sel;
  logic              fl_wr, rm_wr;
  logic [FLAG_W-1:0] fl_mask;
  logic [RM_W-1:0]   rm_mask;
  logic [RM_W-1:0]   no_acc;

  assign op      = csr_op_e'(req_op);
  assign fl_sel  = sel.flags || sel.whole;
  assign rm_sel  = sel.mode  || sel.whole;
  // Named events for the checker: a software update of each field.
  assign fl_wr   = fl_sel && op_modifies(op);
  assign rm_wr   = rm_sel && op_modifies(op);
  assign fl_mask = req_wdata[FLAG_W-1:0];
  assign rm_mask = sel.whole ? req_wdata[WORD_W-1:FLAG_W] : req_wdata[RM_W-1:0];
  assign no_acc  = '0;

  fpcsr_decode #(
    .ADDR_W(ADDR_W), .ADDR_FLAGS(ADDR_FLAGS), .ADDR_RM(ADDR_RM), .ADDR_ALL(ADDR_ALL)
  ) u_dec (
    .req(req), .addr(req_addr), .sel(sel), .hit(req_hit)
  );

  fpcsr_field_reg #(.W(FLAG_W), .ACCUM(1'b1)) u_flags (
    .clk(clk), .rst_n(rst_n), .sel(fl_sel), .op(op), .mask(fl_mask),
    .acc_en(acc_valid), .acc_val(acc_flags), .q(flags_out)
  );

  fpcsr_field_reg #(.W(RM_W), .ACCUM(1'b0)) u_mode (
    .clk(clk), .rst_n(rst_n), .sel(rm_sel), .op(op), .mask(rm_mask),
    .acc_en(1'b0), .acc_val(no_acc), .q(rm_out)
  );

  fpcsr_read_mux #(.XLEN(XLEN), .RM_W(RM_W), .FLAG_W(FLAG_W)) u_rd (
    .sel(sel), .rm_q(rm_out), .fl_q(flags_out), .rd_data(rd_data)
  );

endmodule

// File: rtl/fpcsr_unit_chk.sv
module fpcsr_unit_chk #(
  parameter int XLEN   = 32,
  parameter int RM_W   = 3,
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              req_hit,
  input logic [XLEN-1:0]   rd_data,
  input logic              acc_valid,
  input logic [FLAG_W-1:0] acc_flags,
  input logic [RM_W-1:0]   rm_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic              fl_wr,
  input logic              rm_wr
);

  localparam int WORD_W = RM_W + FLAG_W;

  a_r4_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rm_wr |=> $stable(rm_out));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_wr |=> ((flags_out & $past(flags_out)) == $past(flags_out)));

  a_r7_acc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !fl_wr) |=> ((flags_out & $past(acc_flags)) == $past(acc_flags)));

  a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_hit) |-> (rd_data == '0 && !fl_wr && !rm_wr));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (rd_data == '0 && !req_hit));

  a_r2_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[XLEN-1:WORD_W] == '0);

endmodule

bind fpcsr_unit fpcsr_unit_chk #(.XLEN(XLEN), .RM_W(RM_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_hit(req_hit), .rd_data(rd_data),
  .acc_valid(acc_valid), .acc_flags(acc_flags), .rm_out(rm_out),
  .flags_out(flags_out), .fl_wr(fl_wr), .rm_wr(rm_wr)
);

// File: tb/fpcsr_unit_test.sv
`timescale 1ns/1ps
module fpcsr_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        req_hit;
  logic        acc_valid = 1'b0;
  logic [4:0]  acc_flags = '0;
  logic [2:0]  rm_out;
  logic [4:0]  flags_out;

  int compared = 0;
  int mismatched = 0;
  int m_rm = 0;
  int m_fl = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fpcsr_unit uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_op(req_op),
    .req_wdata(req_wdata), .rd_data(rd_data), .req_hit(req_hit),
    .acc_valid(acc_valid), .acc_flags(acc_flags), .rm_out(rm_out), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // View value in the reference: address 1 flags, 2 mode, 3 whole word.
  function automatic int view_of(input int a);
    case (a)
      1: return m_fl;
      2: return m_rm;
      3: return m_rm * 32 + m_fl;
      default: return 0;
    endcase
  endfunction

  task automatic step(input string tag, input bit r, input int a, input int op,
                      input logic [31:0] wd, input bit av, input int af);
    logic [31:0] nv;
    int          old;
    bit          mapped;
    @(negedge clk);
    req = r; req_addr = 12'(a); req_op = 2'(op); req_wdata = wd;
    acc_valid = av; acc_flags = 5'(af);
    #2;
    mapped = r && (a >= 1 && a <= 3);
    old    = mapped ? view_of(a) : 0;
    chk({tag, " rd"}, rd_data, 32'(old));
    chk("R6 hit", {31'd0, req_hit}, {31'd0, mapped});
    chk("R10 mode", {29'd0, rm_out}, 32'(m_rm));
    chk("R10 flags", {27'd0, flags_out}, 32'(m_fl));
    @(posedge clk);
    if (mapped && op != 0) begin
      case (op)
        1: nv = wd;
        2: nv = 32'(old) | wd;
        default: nv = 32'(old) & ~wd;
      endcase
      if (a == 1) m_fl = int'(nv & 32'h1f);
      if (a == 2) m_rm = int'(nv & 32'h7);
      if (a == 3) begin m_fl = int'(nv & 32'h1f); m_rm = int'((nv >> 5) & 32'h7); end
    end
    if (av && !(mapped && op != 0 && (a == 1 || a == 3))) m_fl = m_fl | af;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", {29'd0, rm_out}, 32'd0);
    chk("R1 flags", {27'd0, flags_out}, 32'd0);
    chk("R1 rd", rd_data, 32'd0);
    rst_n = 1'b1;

    step("R6", 1, 3, 1, 32'h1234, 0, 0);       // old whole word 0
    step("R2", 1, 3, 0, 0, 0, 0);              // reads 0x34
    step("R3", 1, 1, 0, 0, 0, 0);              // reads 0x14
    step("R4", 1, 2, 1, 32'h2, 0, 0);          // returns 1
    step("R4", 1, 3, 0, 0, 0, 0);              // 0x54
    step("R5", 1, 1, 3, 32'h4, 0, 0);          // clear returns 0x14
    step("R5", 1, 3, 0, 0, 0, 0);              // 0x50
    step("R5", 1, 1, 2, 32'h3, 0, 0);          // set
    step("R5", 1, 2, 2, 32'h4, 0, 0);          // set mode bit
    step("R5", 1, 3, 3, 32'hE0, 0, 0);         // clear mode via whole word
    step("R3", 1, 2, 1, 32'h5, 0, 0);
    step("R3", 1, 1, 1, 32'hFFFF_FFE0, 0, 0);  // flags to 0, mode kept
    step("R3", 1, 3, 0, 0, 0, 0);
    step("R9", 1, 7, 1, 32'hFF, 0, 0);
    step("R9", 1, 12'h103, 1, 32'hFF, 0, 0);
    step("R2", 1, 3, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 5'h10);          // invalid flag raised
    step("R7", 0, 0, 0, 0, 1, 5'h01);          // inexact flag raised
    step("R7", 1, 1, 0, 0, 0, 0);              // 0x11
    step("R8", 1, 1, 1, 32'h0, 1, 5'h04);      // write wins
    step("R8", 1, 1, 0, 0, 0, 0);              // 0
    step("R8", 1, 2, 1, 32'h3, 1, 5'h02);      // mode write keeps accumulation
    step("R8", 1, 3, 0, 0, 1, 5'h08);          // read-only keeps accumulation
    step("R8", 1, 3, 2, 32'h1, 1, 5'h10);      // set wins, 0x10 dropped
    step("R8", 1, 3, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int a;
      case ($urandom_range(0, 4))
        0: a = 1; 1: a = 2; 2: a = 3; 3: a = 0; default: a = 12'h203;
      endcase
      step("R6 random", $urandom_range(0, 3) != 0, a, int'($urandom_range(0, 3)),
           $urandom(), $urandom_range(0, 1) == 1, int'($urandom_range(0, 31)));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule